// File: doc/BRIEF.md
# Broadcast Context Memory Controller

This block holds configuration words for an 8 by 8 grid of processing cells and delivers them in a broadcast manner. Storage is organised as up to 32 planes. Each plane carries one 32-bit context word per row and one per column, so a single word configures a whole row or a whole column of cells. A DMA engine fills the store through a load port, writing one word per cycle into a chosen plane, direction and line.

The host issues execute commands. Each command names a plane, a broadcast direction (row or column) and a broadcast mode (every line, or one selected line). One clock later the block drives the matching per-row or per-column context buses together with a per-line enable mask. A small state machine tracks which plane is active. Loads into any other plane go ahead while execution continues, with no stall. A load aimed at the active plane is refused and flagged.

State machine: `ST_IDLE` (no active plane) and `ST_RUN` (one plane active).
- Transition `GO`: `ST_IDLE` to `ST_RUN` when an execute command arrives.
- Transition `SWITCH`: `ST_RUN` to `ST_RUN`, taking a new active plane on each execute.
- Transition `HALT`: `ST_RUN` to `ST_IDLE` when halt is raised without an execute in the same cycle.

Top module: `ctx_bcast_ctrl`

## Requirements
- R1: The load port addresses a word as {plane[4:0], dir, line[2:0]}, where dir 0 selects the row word and dir 1 the column word. An accepted load stores `ld_data` there, and later executes of that plane and direction return it.
- R2: An execute with `ex_dir`=0 (row) and `ex_sel`=0 (all lines) makes `row_en` equal 8'hFF one clock later, with row i's bus slice `row_ctx[32*i+:32]` holding the row word of line i of that plane. `col_en` is 0 in that cycle.
- R3: An execute with `ex_dir`=1 (column) and `ex_sel`=0 makes `col_en` equal 8'hFF one clock later, with `col_ctx[32*i+:32]` holding the column word of line i. `row_en` is 0 in that cycle.
- R4: An execute with `ex_sel`=1 enables only line `ex_line` of the chosen direction one clock later and updates only that line's bus. Every other line's enable bit is 0 and its bus keeps its previous value.
- R5: A load whose plane equals the active plane while in `ST_RUN` is refused. `ld_conflict` is 1 for exactly the next cycle, and the stored words keep their old contents.
- R6: Loads into planes other than the active one are accepted in any cycle, including cycles with an execute, and never delay or alter the execute outputs.
- R7: After reset the block is in `ST_IDLE` and loads into any plane are accepted. An execute enters or stays in `ST_RUN` with its plane active. `ex_halt` without `ex_valid` returns the block to `ST_IDLE`, after which the previously active plane accepts loads.
- R8: While reset is held, `row_en`, `col_en`, `ld_conflict` and both context buses are all zero.
- R9: A load that names the same plane as an execute in the same cycle is refused with `ld_conflict`, even from `ST_IDLE`.
- R10: The enable masks are single-cycle pulses. In a cycle following no execute, `row_en` and `col_en` are 0 and every bus holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load word request from the DMA engine |
| ld_plane | input | 5 | Target plane of the load |
| ld_dir | input | 1 | 0 = row word, 1 = column word |
| ld_line | input | 3 | Target row or column index |
| ld_data | input | 32 | Context word to store |
| ex_valid | input | 1 | Execute command |
| ex_plane | input | 5 | Plane to execute |
| ex_dir | input | 1 | 0 = row broadcast, 1 = column broadcast |
| ex_sel | input | 1 | 0 = all lines, 1 = selected line only |
| ex_line | input | 3 | Selected line when `ex_sel`=1 |
| ex_halt | input | 1 | Release the active plane |
| ld_conflict | output | 1 | Pulse: the previous cycle's load was refused |
| row_ctx | output | 256 | Eight 32-bit row buses, row i at bits 32*i+:32 |
| row_en | output | 8 | Per-row enable mask |
| col_ctx | output | 256 | Eight 32-bit column buses, column i at bits 32*i+:32 |
| col_en | output | 8 | Per-column enable mask |

## Verification
The assertions check on every cycle that enables appear only one clock after an execute, and that they do appear then. They also check that row and column masks are never active together, that a selective execute raises exactly one enable bit, that a disabled line's bus is stable, and that the conflict flag follows a load. Only the bench's scenarios can show that the right word reaches the right bus. The same holds for the old contents surviving a refused load, for a halted plane becoming writable again, and for loads into other planes leaving a running broadcast undisturbed. The bench shows these by comparing every cycle against its own model of the store and the active plane.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic {
        DIR_ROW = 1'b0,
        DIR_COL = 1'b1
    } bcast_dir_t;
endpackage

// File: rtl/ctx_store.sv
module ctx_store #(
    parameter int N_LINES  = 8,
    parameter int WORD_W   = 32,
    parameter int N_PLANES = 32
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(N_PLANES)-1:0]   wr_plane,
    input  logic                          wr_dir,
    input  logic [$clog2(N_LINES)-1:0]    wr_line,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [$clog2(N_PLANES)-1:0]   rd_plane,
    input  logic                          rd_dir,
    output logic [N_LINES*WORD_W-1:0]     rd_words
);
    localparam int LINE_W = $clog2(N_LINES);
    localparam int PLANE_W = $clog2(N_PLANES);
    localparam int ADDR_W = PLANE_W + 1 + LINE_W;
    localparam int DEPTH  = N_PLANES * 2 * N_LINES;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[ADDR_W'({wr_plane, wr_dir, wr_line})] <= wr_data;
        end
    end

    for (genvar l = 0; l < N_LINES; l++) begin : g_rd
        assign rd_words[l*WORD_W +: WORD_W] =
            mem[ADDR_W'({rd_plane, rd_dir, LINE_W'(l)})];
    end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_pkg::*;
#(
    parameter int N_PLANES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_valid,
    input  logic [$clog2(N_PLANES)-1:0]   ld_plane,
    input  logic                          ex_valid,
    input  logic [$clog2(N_PLANES)-1:0]   ex_plane,
    input  logic                          ex_halt,
    output logic                          ld_accept,
    output logic                          ld_conflict
);
    localparam int PLANE_W = $clog2(N_PLANES);

    seq_state_t         state_q, state_d;
    logic [PLANE_W-1:0] act_q;
    logic               refuse;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ex_valid) state_d = ST_RUN;               // GO
            ST_RUN:  if (!ex_valid && ex_halt) state_d = ST_IDLE;  // HALT, else SWITCH
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        refuse = ((state_q == ST_RUN) && (ld_plane == act_q)) ||
                 (ex_valid && (ex_plane == ld_plane));
        ld_accept = ld_valid && !refuse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q       <= '0;
            ld_conflict <= 1'b0;
        end else begin
            if (ex_valid) act_q <= ex_plane;
            ld_conflict <= ld_valid && refuse;
        end
    end
endmodule

// File: rtl/ctx_drive.sv
module ctx_drive
    import ctx_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int WORD_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ex_valid,
    input  logic                          ex_dir,
    input  logic                          ex_sel,
    input  logic [$clog2(N_LINES)-1:0]    ex_line,
    input  logic [N_LINES*WORD_W-1:0]     rd_words,
    output logic [N_LINES*WORD_W-1:0]     row_ctx,
    output logic [N_LINES-1:0]            row_en,
    output logic [N_LINES*WORD_W-1:0]     col_ctx,
    output logic [N_LINES-1:0]            col_en
);
    localparam int LINE_W = $clog2(N_LINES);

    bcast_dir_t dir;
    assign dir = bcast_dir_t'(ex_dir);

    for (genvar l = 0; l < N_LINES; l++) begin : g_lane
        logic hit, row_hit, col_hit;
        assign hit     = ex_valid && (!ex_sel || (ex_line == LINE_W'(l)));
        assign row_hit = hit && (dir == DIR_ROW);
        assign col_hit = hit && (dir == DIR_COL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_en[l]                    <= 1'b0;
                col_en[l]                    <= 1'b0;
                row_ctx[l*WORD_W +: WORD_W]  <= '0;
                col_ctx[l*WORD_W +: WORD_W]  <= '0;
            end else begin
                row_en[l] <= row_hit;
                col_en[l] <= col_hit;
                if (row_hit) row_ctx[l*WORD_W +: WORD_W] <= rd_words[l*WORD_W +: WORD_W];
                if (col_hit) col_ctx[l*WORD_W +: WORD_W] <= rd_words[l*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/ctx_bcast_ctrl.sv
module ctx_bcast_ctrl #(
    parameter int N_LINES  = 8,
    parameter int WORD_W   = 32,
    parameter int N_PLANES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_valid,
    input  logic [$clog2(N_PLANES)-1:0]   ld_plane,
    input  logic                          ld_dir,
    input  logic [$clog2(N_LINES)-1:0]    ld_line,
    input  logic [WORD_W-1:0]             ld_data,
    input  logic                          ex_valid,
    input  logic [$clog2(N_PLANES)-1:0]   ex_plane,
    input  logic                          ex_dir,
    input  logic                          ex_sel,
    input  logic [$clog2(N_LINES)-1:0]    ex_line,
    input  logic                          ex_halt,
    output logic                          ld_conflict,
    output logic [N_LINES*WORD_W-1:0]     row_ctx,
    output logic [N_LINES-1:0]            row_en,
    output logic [N_LINES*WORD_W-1:0]     col_ctx,
    output logic [N_LINES-1:0]            col_en
);
    logic                       ld_accept;
    logic [N_LINES*WORD_W-1:0]  rd_words;

    ctx_seq #(.N_PLANES(N_PLANES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_plane(ld_plane),
        .ex_valid(ex_valid), .ex_plane(ex_plane), .ex_halt(ex_halt),
        .ld_accept(ld_accept), .ld_conflict(ld_conflict)
    );

    ctx_store #(.N_LINES(N_LINES), .WORD_W(WORD_W), .N_PLANES(N_PLANES)) u_store (
        .clk(clk),
        .wr_en(ld_accept), .wr_plane(ld_plane), .wr_dir(ld_dir),
        .wr_line(ld_line), .wr_data(ld_data),
        .rd_plane(ex_plane), .rd_dir(ex_dir), .rd_words(rd_words)
    );

    ctx_drive #(.N_LINES(N_LINES), .WORD_W(WORD_W)) u_drive (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_dir(ex_dir), .ex_sel(ex_sel), .ex_line(ex_line),
        .rd_words(rd_words),
        .row_ctx(row_ctx), .row_en(row_en), .col_ctx(col_ctx), .col_en(col_en)
    );
endmodule

// File: rtl/ctx_bcast_chk.sv
module ctx_bcast_chk #(
    parameter int N_LINES = 8,
    parameter int WORD_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ld_valid,
    input logic                      ex_valid,
    input logic                      ex_sel,
    input logic                      ld_conflict,
    input logic [N_LINES*WORD_W-1:0] row_ctx,
    input logic [N_LINES-1:0]        row_en,
    input logic [N_LINES*WORD_W-1:0] col_ctx,
    input logic [N_LINES-1:0]        col_en
);
    assert_conflict_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_conflict |-> $past(ld_valid));

    assert_enable_after_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|row_en) || (|col_en)) |-> $past(ex_valid));

    assert_exec_gives_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> ((|row_en) || (|col_en)));

    assert_one_direction_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((|row_en) && (|col_en)));

    assert_single_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_sel) |=> ($countones({row_en, col_en}) == 1));

    for (genvar l = 0; l < N_LINES; l++) begin : g_hold
        assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !row_en[l] |-> $stable(row_ctx[l*WORD_W +: WORD_W]));
        assert_col_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !col_en[l] |-> $stable(col_ctx[l*WORD_W +: WORD_W]));
    end
endmodule

bind ctx_bcast_ctrl ctx_bcast_chk #(.N_LINES(N_LINES), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ex_valid(ex_valid),
    .ex_sel(ex_sel), .ld_conflict(ld_conflict),
    .row_ctx(row_ctx), .row_en(row_en), .col_ctx(col_ctx), .col_en(col_en)
);

// File: tb/test_ctx_bcast_ctrl.sv
module test_ctx_bcast_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 0, ld_dir = 0, ex_valid = 0, ex_dir = 0, ex_sel = 0, ex_halt = 0;
    logic [4:0] ld_plane = 0, ex_plane = 0;
    logic [2:0] ld_line = 0, ex_line = 0;
    logic [31:0] ld_data = 0;
    logic ld_conflict;
    logic [NL*WW-1:0] row_ctx, col_ctx;
    logic [NL-1:0] row_en, col_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_bcast_ctrl i_ctx_bcast_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_plane(ld_plane), .ld_dir(ld_dir), .ld_line(ld_line),
        .ld_data(ld_data), .ex_valid(ex_valid), .ex_plane(ex_plane), .ex_dir(ex_dir),
        .ex_sel(ex_sel), .ex_line(ex_line), .ex_halt(ex_halt),
        .ld_conflict(ld_conflict), .row_ctx(row_ctx), .row_en(row_en),
        .col_ctx(col_ctx), .col_en(col_en)
    );

    // reference model state
    logic [31:0] ref_mem [int];
    logic [31:0] e_row [NL];
    logic [31:0] e_col [NL];
    logic [NL-1:0] e_ren = 0, e_cen = 0;
    logic e_conf = 0;
    bit running = 0;
    int act = 0;
    bit armed = 0;
    int total = 0, bad = 0;
    string req = "R8";

    function automatic int key(int p, int d, int l);
        return p * 16 + d * 8 + l;
    endfunction

    function automatic logic [31:0] word_of(int p, int d, int l);
        return 32'hC0DE_0000 ^ (p << 12) ^ (d << 8) ^ (l << 4) ^ 32'h5;
    endfunction

    task automatic chk(string what, logic [255:0] act_v, logic [255:0] exp_v);
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act_v, exp_v);
        end
    endtask

    task automatic compare();
        logic [NL*WW-1:0] er, ec;
        for (int i = 0; i < NL; i++) begin
            er[i*WW +: WW] = e_row[i];
            ec[i*WW +: WW] = e_col[i];
        end
        chk("ld_conflict", 256'(ld_conflict), 256'(e_conf));
        chk("row_en", 256'(row_en), 256'(e_ren));
        chk("col_en", 256'(col_en), 256'(e_cen));
        chk("row_ctx", row_ctx, er);
        chk("col_ctx", col_ctx, ec);
    endtask

    task automatic model_update();
        bit refuse;
        if (!rst_n) begin
            e_conf = 0; e_ren = 0; e_cen = 0; running = 0; act = 0;
            for (int i = 0; i < NL; i++) begin e_row[i] = 0; e_col[i] = 0; end
            return;
        end
        refuse = (running && int'(ld_plane) == act) || (ex_valid && ex_plane == ld_plane);
        e_conf = ld_valid && refuse;
        e_ren = 0; e_cen = 0;
        if (ex_valid) begin
            for (int i = 0; i < NL; i++) begin
                if (!ex_sel || int'(ex_line) == i) begin
                    if (!ex_dir) begin e_ren[i] = 1; e_row[i] = ref_mem[key(ex_plane, 0, i)]; end
                    else begin e_cen[i] = 1; e_col[i] = ref_mem[key(ex_plane, 1, i)]; end
                end
            end
        end
        if (ld_valid && !refuse) ref_mem[key(ld_plane, ld_dir, ld_line)] = ld_data;
        if (ex_valid) begin running = 1; act = ex_plane; end
        else if (ex_halt) running = 0;
    endtask

    // one clock: compare results of the last edge, then apply new inputs
    task automatic cyc(bit lv, int lp, bit ld, int ll, logic [31:0] dat,
                       bit ev, int ep, bit ed, bit es, int el, bit h);
        @(negedge clk);
        if (armed) compare();
        ld_valid = lv; ld_plane = 5'(lp); ld_dir = ld; ld_line = 3'(ll); ld_data = dat;
        ex_valid = ev; ex_plane = 5'(ep); ex_dir = ed; ex_sel = es; ex_line = 3'(el);
        ex_halt = h;
        model_update();
        armed = 1;
    endtask

    task automatic idle(); cyc(0,0,0,0,0, 0,0,0,0,0, 0); endtask

    task automatic fill_plane(int p, logic [31:0] salt);
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < NL; l++)
                cyc(1, p, d[0], l, word_of(p, d, l) ^ salt, 0,0,0,0,0, 0);
    endtask

    task automatic exec(int p, bit d, bit s, int l);
        cyc(0,0,0,0,0, 1, p, d, s, l, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R8: outputs zero while reset is held
        req = "R8";
        repeat (3) idle();
        @(negedge clk); compare(); rst_n = 1; model_update();
        // R7: idle after reset, every plane writable; R1: load addressing
        req = "R1";
        fill_plane(3, 32'h0);
        fill_plane(5, 32'h1111_0000);
        fill_plane(7, 32'h0);
        // R2: row broadcast, all lines
        req = "R2";
        exec(3, 0, 0, 0);
        // R10: enables drop after one cycle, buses hold
        req = "R10";
        idle(); idle();
        // R3: column broadcast, all lines
        req = "R3";
        exec(3, 1, 0, 0);
        idle();
        // R4: selective row line 5 and column line 0 of plane 5
        req = "R4";
        exec(5, 0, 1, 5);
        exec(5, 1, 1, 0);
        exec(5, 0, 1, 2);
        idle();
        // R5: plane 5 is active; loads into it are refused, contents unchanged
        req = "R5";
        cyc(1, 5, 0, 2, 32'hDEAD_BEEF, 0,0,0,0,0, 0);
        cyc(1, 5, 1, 7, 32'hBAD0_BAD0, 0,0,0,0,0, 0);
        idle();
        exec(5, 0, 0, 0);
        exec(5, 1, 0, 0);
        idle();
        // R6: loads into plane 7 while plane 5 executes every cycle
        req = "R6";
        for (int l = 0; l < NL; l++)
            cyc(1, 7, 0, l, 32'h7700_0000 + 32'(l), 1, 5, l[0], 0, 0, 0);
        exec(7, 0, 0, 0);
        idle();
        // R7: halt releases plane 7; loads then accepted
        req = "R7";
        cyc(0,0,0,0,0, 0,0,0,0,0, 1);
        cyc(1, 7, 0, 4, 32'hA5A5_0004, 0,0,0,0,0, 0);
        exec(7, 0, 1, 4);
        // R7: halt with execute in the same cycle keeps running
        cyc(0,0,0,0,0, 1, 3, 1, 1, 6, 1);
        cyc(1, 3, 1, 6, 32'h3333_3333, 0,0,0,0,0, 0);
        idle();
        // R9: load and execute of the same plane in one cycle from idle
        req = "R9";
        cyc(0,0,0,0,0, 0,0,0,0,0, 1);
        idle();
        cyc(1, 9, 0, 1, 32'h9999_0001, 1, 9, 0, 0, 0, 0);
        cyc(0,0,0,0,0, 0,0,0,0,0, 1);
        cyc(1, 9, 0, 1, 32'h9999_0002, 0,0,0,0,0, 0);
        exec(9, 0, 1, 1);
        idle(); idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule